// File: doc/BRIEF.md
# Scanline-Fed Two-Bit Sprite Engine

This block overlays a small set of narrow sprites on a video line. Image data is never stored for a whole sprite. During horizontal blanking, a fetch agent outside the block writes one 64-bit row word for every sprite that appears on the coming line. Each word holds 32 pixels of 2 bits. Pixel k sits in bits [2k+1:2k], so pixel 0 is the leftmost. The block keeps two registers per sprite. A pending register takes the load, and a display register feeds the beam. When the line starts, the pending word moves into the display register. A load for the next line therefore never disturbs the line being drawn.

Each sprite is positioned by a horizontal start coordinate. A sprite's 2-bit code of 0 is transparent. Codes 1 to 3 pick an entry in that sprite's own three-colour palette. Sprites 2p and 2p+1 can be linked. The pair then draws as one sprite at the even sprite's position, and its pixels are 4-bit indices into a shared 16-entry palette. Where opaque sprites overlap, the lowest-numbered sprite wins.

A three-state line sequencer controls the line:
- S_BLANK waits for `line_start`. Taking it (transition BLANK_TO_WAIT) moves every row word to its display register.
- S_WAIT waits for `active`. The transition is WAIT_TO_SHOW.
- S_SHOW lasts until `active` falls. The transition is SHOW_TO_BLANK.

Top module: `sprite_line_engine`

## Requirements
- R1: After reset, `pix_valid` is 0, `pix_out` is 0, and no sprite has a row.
- R2: A row word loaded in blanking is taken at the `line_start` cycle. On that line, with `active` high and `beam_x` = pos + k (0 ≤ k < 32), the pixel code is bits [2k+1:2k] of the word. The result appears on `pix_out`/`pix_valid` after the next rising edge.
- R3: Where no sprite has an opaque pixel, `pix_valid` is 0 and `pix_out` is 0. Code 0 (and linked index 0) is transparent.
- R4: Code c in 1..3 outputs the sprite's palette entry c, written through `pal_slot` = c. A write to slot 0 has no effect.
- R5: A row loaded during an active line, or in the same cycle as `line_start`, does not change the current line. It is shown on the following line.
- R6: A row is used for one line only. A sprite that gets no new load before `line_start` is transparent on that line.
- R7: Among overlapping opaque sprites, the lowest-numbered one is output.
- R8: When `link_en[p]` is 1, the pair index is {odd sprite code, even sprite code}. The even sprite gives the low 2 bits, the window is at the even sprite's position, and the colour is `pal16` entry index. Index 0 is transparent. The odd sprite's own position and palette have no effect.
- R9: Outside the 32-pixel window (`beam_x` < pos, or `beam_x` ≥ pos + 32) a sprite is transparent. No pixel is valid in a cycle after `active` was low.
- R10: Sequencing: `line_start` is accepted only in S_BLANK. `active` cycles that are not preceded by an accepted `line_start` produce no pixels. The line ends when `active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Row word load strobe |
| ld_sel | input | SW | Sprite that receives the row |
| ld_word | input | 64 | Row word, 32 pixels of 2 bits |
| pos_we | input | 1 | Position write strobe |
| pos_sel | input | SW | Sprite whose position is written |
| pos_x_in | input | XW | Horizontal start coordinate |
| pal_we | input | 1 | Per-sprite palette write strobe |
| pal_sel | input | SW | Sprite whose palette is written |
| pal_slot | input | 2 | Palette slot 1..3 (0 ignored) |
| pal_data | input | CW | Colour value |
| pal16_we | input | 1 | Shared 16-entry palette write strobe |
| pal16_idx | input | 4 | Shared palette entry |
| pal16_data | input | CW | Colour value |
| link_en | input | NSPR/2 | Pair link enables |
| line_start | input | 1 | Line start pulse, given before the first active pixel |
| active | input | 1 | Visible part of the line |
| beam_x | input | XW | Current horizontal coordinate |
| pix_valid | output | 1 | Registered: an opaque sprite pixel is present |
| pix_out | output | CW | Registered sprite colour, 0 when not valid |

## Verification
Each pixel result is due exactly one rising edge after the cycle in which `beam_x` and `active` are driven. A row load or `line_start` takes effect at the edge where it is sampled, so it first shapes the pixels of the cycles that follow. The driver computes the expected value of every driven cycle from its own line model and queues it before that edge. The monitor pops one item 1 ns after each edge, so each compare lands on the register output of the matching cycle. Blanking and configuration cycles are queued too, which checks that those cycles stay dark.

// File: rtl/sle_pkg.sv
package sle_pkg;
    localparam int ROW_BITS = 64;
    localparam int ROW_PIX  = 32;

    typedef enum logic [1:0] {
        S_BLANK = 2'd0,
        S_WAIT  = 2'd1,
        S_SHOW  = 2'd2
    } line_state_t;
endpackage

// File: rtl/sle_row_store.sv
module sle_row_store #(
    parameter int NSPR = 4,
    parameter int SW   = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ld_valid,
    input  logic [SW-1:0]                         ld_sel,
    input  logic [sle_pkg::ROW_BITS-1:0]          ld_word,
    input  logic                                  xfer,
    output logic [NSPR-1:0][sle_pkg::ROW_BITS-1:0] disp_row
);
    logic [NSPR-1:0][sle_pkg::ROW_BITS-1:0] pend_row;
    logic [NSPR-1:0]                        pend_v;

    for (genvar i = 0; i < NSPR; i++) begin : g_spr
        logic hit_ld;
        assign hit_ld = ld_valid && (ld_sel == SW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_row[i] <= '0;
                pend_v[i]   <= 1'b0;
                disp_row[i] <= '0;
            end else begin
                if (xfer)
                    disp_row[i] <= pend_v[i] ? pend_row[i] : '0;
                if (hit_ld) begin
                    pend_row[i] <= ld_word;
                    pend_v[i]   <= 1'b1;
                end else if (xfer) begin
                    pend_v[i]   <= 1'b0;
                end
            end
        end

        AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            xfer |=> disp_row[i] == ($past(pend_v[i]) ? $past(pend_row[i]) : '0)); // R2
        AST_HOLD_ROW: assert property (@(posedge clk) disable iff (!rst_n)
            !xfer |=> $stable(disp_row[i])); // R5
    end
endmodule

// File: rtl/sle_palette.sv
module sle_palette #(
    parameter int NSPR = 4,
    parameter int SW   = 2,
    parameter int CW   = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pal_we,
    input  logic [SW-1:0]                 pal_sel,
    input  logic [1:0]                    pal_slot,
    input  logic [CW-1:0]                 pal_data,
    input  logic                          pal16_we,
    input  logic [3:0]                    pal16_idx,
    input  logic [CW-1:0]                 pal16_data,
    output logic [NSPR-1:0][2:0][CW-1:0]  spr_pal,
    output logic [15:0][CW-1:0]           pal16
);
    for (genvar i = 0; i < NSPR; i++) begin : g_spr
        for (genvar c = 1; c < 4; c++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    spr_pal[i][c-1] <= '0;
                else if (pal_we && pal_sel == SW'(i) && pal_slot == 2'(c))
                    spr_pal[i][c-1] <= pal_data;
            end
        end
    end

    for (genvar e = 0; e < 16; e++) begin : g_shared
        always_ff @(posedge clk) begin
            if (!rst_n)
                pal16[e] <= '0;
            else if (pal16_we && pal16_idx == 4'(e))
                pal16[e] <= pal16_data;
        end
    end
endmodule

// File: rtl/sle_pixel_pick.sv
module sle_pixel_pick #(
    parameter int NSPR = 4,
    parameter int XW   = 11,
    parameter int CW   = 12
) (
    input  logic [XW-1:0]                           beam_x,
    input  logic [NSPR-1:0][XW-1:0]                 pos_x,
    input  logic [NSPR-1:0][sle_pkg::ROW_BITS-1:0]  disp_row,
    input  logic [NSPR/2-1:0]                       link_en,
    input  logic [NSPR-1:0][2:0][CW-1:0]            spr_pal,
    input  logic [15:0][CW-1:0]                     pal16,
    output logic                                    hit,
    output logic [CW-1:0]                           color
);
    localparam int NPAIR = NSPR / 2;

    logic [NSPR-1:0][1:0] code;
    logic [NSPR-1:0][1:0] pair_hi;
    logic [NPAIR-1:0][3:0] pidx;

    for (genvar i = 0; i < NSPR; i++) begin : g_win
        logic [XW-1:0] off;
        logic          inwin;
        assign off   = beam_x - pos_x[i];
        assign inwin = (beam_x >= pos_x[i]) && (off < XW'(sle_pkg::ROW_PIX));
        assign code[i] = inwin ? disp_row[i][{off[4:0], 1'b0} +: 2] : 2'b00;
        if (i % 2 == 0 && i + 1 < NSPR) begin : g_pair
            assign pair_hi[i]   = inwin ? disp_row[i+1][{off[4:0], 1'b0} +: 2] : 2'b00;
            assign pidx[i/2]    = {pair_hi[i], code[i]};
        end else begin : g_nopair
            assign pair_hi[i] = 2'b00;
        end
    end

    always_comb begin
        hit   = 1'b0;
        color = '0;
        for (int i = NSPR - 1; i >= 0; i--) begin
            if (i / 2 < NPAIR && link_en[i/2]) begin
                if (i % 2 == 0 && pidx[i/2] != 4'd0) begin
                    hit   = 1'b1;
                    color = pal16[pidx[i/2]];
                end
            end else if (code[i] != 2'b00) begin
                hit   = 1'b1;
                color = spr_pal[i][code[i] - 2'd1];
            end
        end
    end
endmodule

// File: rtl/sprite_line_engine.sv
module sprite_line_engine #(
    parameter int NSPR = 4,
    parameter int XW   = 11,
    parameter int CW   = 12,
    parameter int SW   = (NSPR > 1) ? $clog2(NSPR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_valid,
    input  logic [SW-1:0]        ld_sel,
    input  logic [63:0]          ld_word,
    input  logic                 pos_we,
    input  logic [SW-1:0]        pos_sel,
    input  logic [XW-1:0]        pos_x_in,
    input  logic                 pal_we,
    input  logic [SW-1:0]        pal_sel,
    input  logic [1:0]           pal_slot,
    input  logic [CW-1:0]        pal_data,
    input  logic                 pal16_we,
    input  logic [3:0]           pal16_idx,
    input  logic [CW-1:0]        pal16_data,
    input  logic [NSPR/2-1:0]    link_en,
    input  logic                 line_start,
    input  logic                 active,
    input  logic [XW-1:0]        beam_x,
    output logic                 pix_valid,
    output logic [CW-1:0]        pix_out
);
    import sle_pkg::*;

    line_state_t state_q, state_d;
    logic                            xfer;
    logic [NSPR-1:0][XW-1:0]         pos_x;
    logic [NSPR-1:0][ROW_BITS-1:0]   disp_row;
    logic [NSPR-1:0][2:0][CW-1:0]    spr_pal;
    logic [15:0][CW-1:0]             pal16;
    logic                            hit;
    logic [CW-1:0]                   color;

    assign xfer = line_start && (state_q == S_BLANK);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_BLANK;
        else        state_q <= state_d;
    end

    // transitions: BLANK_TO_WAIT, WAIT_TO_SHOW, SHOW_TO_BLANK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_BLANK: if (line_start) state_d = S_WAIT;
            S_WAIT:  if (active)     state_d = S_SHOW;
            S_SHOW:  if (!active)    state_d = S_BLANK;
            default:                 state_d = S_BLANK;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_out   <= '0;
        end else if (active && state_q != S_BLANK && hit) begin
            pix_valid <= 1'b1;
            pix_out   <= color;
        end else begin
            pix_valid <= 1'b0;
            pix_out   <= '0;
        end
    end

    for (genvar i = 0; i < NSPR; i++) begin : g_pos
        always_ff @(posedge clk) begin
            if (!rst_n)                         pos_x[i] <= '0;
            else if (pos_we && pos_sel == SW'(i)) pos_x[i] <= pos_x_in;
        end
    end

    sle_row_store #(.NSPR(NSPR), .SW(SW)) u_rows (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
        .ld_word(ld_word), .xfer(xfer), .disp_row(disp_row)
    );

    sle_palette #(.NSPR(NSPR), .SW(SW), .CW(CW)) u_pal (
        .clk(clk), .rst_n(rst_n), .pal_we(pal_we), .pal_sel(pal_sel),
        .pal_slot(pal_slot), .pal_data(pal_data), .pal16_we(pal16_we),
        .pal16_idx(pal16_idx), .pal16_data(pal16_data),
        .spr_pal(spr_pal), .pal16(pal16)
    );

    sle_pixel_pick #(.NSPR(NSPR), .XW(XW), .CW(CW)) u_pick (
        .beam_x(beam_x), .pos_x(pos_x), .disp_row(disp_row), .link_en(link_en),
        .spr_pal(spr_pal), .pal16(pal16), .hit(hit), .color(color)
    );

    AST_VALID_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(active)); // R9
    AST_DARK_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> pix_out == '0); // R3
    AST_BLANK_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BLANK && line_start) |=> state_q == S_WAIT); // R10
    AST_SHOW_TO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHOW && !active) |=> (state_q == S_BLANK && !pix_valid)); // R10
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BLANK) |=> !pix_valid); // R10
endmodule

// File: tb/sprite_line_engine_tb_top.sv
module sprite_line_engine_tb_top;
    localparam int NSPR = 4;
    localparam int XW   = 11;
    localparam int CW   = 12;
    localparam int SW   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid = 0;  logic [SW-1:0] ld_sel = '0;  logic [63:0] ld_word = '0;
    logic pos_we = 0;    logic [SW-1:0] pos_sel = '0; logic [XW-1:0] pos_x_in = '0;
    logic pal_we = 0;    logic [SW-1:0] pal_sel = '0; logic [1:0] pal_slot = '0;
    logic [CW-1:0] pal_data = '0;
    logic pal16_we = 0;  logic [3:0] pal16_idx = '0;  logic [CW-1:0] pal16_data = '0;
    logic [NSPR/2-1:0] link_en = '0;
    logic line_start = 0; logic active = 0; logic [XW-1:0] beam_x = '0;
    logic pix_valid;
    logic [CW-1:0] pix_out;

    always #5 clk = ~clk;

    sprite_line_engine #(.NSPR(NSPR), .XW(XW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_word(ld_word),
        .pos_we(pos_we), .pos_sel(pos_sel), .pos_x_in(pos_x_in),
        .pal_we(pal_we), .pal_sel(pal_sel), .pal_slot(pal_slot), .pal_data(pal_data),
        .pal16_we(pal16_we), .pal16_idx(pal16_idx), .pal16_data(pal16_data),
        .link_en(link_en), .line_start(line_start), .active(active), .beam_x(beam_x),
        .pix_valid(pix_valid), .pix_out(pix_out)
    );

    typedef struct { logic v; logic [CW-1:0] c; string tag; } exp_t;
    exp_t q[$];
    int checks = 0;
    int failures = 0;

    // bench model
    logic [63:0]   m_pend [NSPR];
    logic          m_pv   [NSPR];
    logic [63:0]   m_disp [NSPR];
    logic [XW-1:0] m_pos  [NSPR];
    logic [CW-1:0] m_pal  [NSPR][4];
    logic [CW-1:0] m_p16  [16];
    int            m_state = 0;

    function automatic logic [1:0] pcode(int s, int off);
        return m_disp[s][2*off +: 2];
    endfunction

    function automatic exp_t expect_now(string tag);
        exp_t e;
        e.v = 1'b0; e.c = '0; e.tag = tag;
        if (!active || m_state == 0) return e;
        for (int s = 0; s < NSPR; s++) begin
            int off;
            off = int'(beam_x) - int'(m_pos[s]);
            if (link_en[s/2] && (s % 2 == 1)) continue;
            if (off < 0 || off >= 32) continue;
            if (link_en[s/2]) begin
                logic [3:0] idx;
                idx = {pcode(s+1, off), pcode(s, off)};
                if (idx != 0) begin e.v = 1'b1; e.c = m_p16[idx]; return e; end
            end else if (pcode(s, off) != 0) begin
                e.v = 1'b1; e.c = m_pal[s][pcode(s, off)]; return e;
            end
        end
        return e;
    endfunction

    task automatic step(input logic ls, input logic act, input int bx, input string tag);
        line_start = ls; active = act; beam_x = XW'(bx);
        #0;
        q.push_back(expect_now(tag));
        @(posedge clk);
        if (m_state == 0 && ls) begin
            for (int s = 0; s < NSPR; s++) begin
                m_disp[s] = m_pv[s] ? m_pend[s] : 64'd0;
                m_pv[s] = 1'b0;
            end
            m_state = 1;
        end else if (m_state == 1 && act) m_state = 2;
        else if (m_state == 2 && !act) m_state = 0;
        if (ld_valid) begin m_pend[ld_sel] = ld_word; m_pv[ld_sel] = 1'b1; end
        if (pos_we) m_pos[pos_sel] = pos_x_in;
        if (pal_we && pal_slot != 0) m_pal[pal_sel][pal_slot] = pal_data;
        if (pal16_we) m_p16[pal16_idx] = pal16_data;
        @(negedge clk);
        ld_valid = 0; pos_we = 0; pal_we = 0; pal16_we = 0;
    endtask

    task automatic load(input int s, input logic [63:0] w, input string tag);
        ld_valid = 1; ld_sel = SW'(s); ld_word = w;
        step(0, 0, 0, tag);
    endtask

    task automatic set_pos(input int s, input int x);
        pos_we = 1; pos_sel = SW'(s); pos_x_in = XW'(x);
        step(0, 0, 0, "R1");
    endtask

    // one line; optional load at beam_x == 30 (mid-line) or with line_start (ls_ld)
    task automatic do_line(input string tag, input int ml_sel, input logic [63:0] ml_word,
                           input logic ls_ld);
        if (ls_ld) begin ld_valid = 1; ld_sel = SW'(ml_sel); ld_word = ml_word; end
        step(1, 0, 0, tag);
        for (int x = 0; x < 64; x++) begin
            if (!ls_ld && ml_sel >= 0 && x == 30) begin
                ld_valid = 1; ld_sel = SW'(ml_sel); ld_word = ml_word;
            end
            step(0, 1, x, tag);
        end
        step(0, 0, 0, tag);
        step(0, 0, 0, tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (pix_valid !== e.v || pix_out !== e.c) begin
                failures++;
                $display("FAIL %s: got valid=%0b pix=%03h, expected valid=%0b pix=%03h",
                         e.tag, pix_valid, pix_out, e.v, e.c);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: got no end, expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSPR; s++) begin
            m_pend[s] = '0; m_pv[s] = 0; m_disp[s] = '0; m_pos[s] = '0;
            for (int c = 0; c < 4; c++) m_pal[s][c] = '0;
        end
        for (int e = 0; e < 16; e++) m_p16[e] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        checks++;
        if (pix_valid !== 1'b0 || pix_out !== '0) begin
            failures++;
            $display("FAIL R1: got valid=%0b pix=%03h, expected valid=0 pix=000", pix_valid, pix_out);
        end

        // palettes (R4: slot 0 write must have no effect)
        for (int s = 0; s < NSPR; s++)
            for (int c = 0; c < 4; c++) begin
                pal_we = 1; pal_sel = SW'(s); pal_slot = 2'(c);
                pal_data = {4'(s + 1), 4'(c), 4'hA};
                step(0, 0, 0, "R4");
            end
        for (int e = 0; e < 16; e++) begin
            pal16_we = 1; pal16_idx = 4'(e); pal16_data = {4'hF, 4'(e), 4'h5};
            step(0, 0, 0, "R8");
        end
        set_pos(0, 10); set_pos(1, 24); set_pos(2, 0); set_pos(3, 50);

        // line A: R2, R3, R4, R9 (window edges at 10 and 42)
        load(0, 64'hE4E4_1B1B_00FF_39C6, "R2");
        do_line("R2/R3/R4/R9", -1, 64'd0, 1'b0);

        // line B: no reload -> transparent (R6); mid-line load of sprite 1 (R5)
        do_line("R6/R5", 1, 64'hFFFF_FFFF_AAAA_5555, 1'b0);

        // line C: sprite 0 reloaded, overlaps sprite 1 (R7); sprite 2 loaded with line_start (R5)
        load(0, 64'h5555_0000_FFFF_AAAA, "R7");
        set_pos(0, 20);
        do_line("R7/R5", 2, 64'h3333_CCCC_3333_CCCC, 1'b1);

        // line D: link pair 0, odd position ignored (R8); sprite 2 now visible
        link_en = 2'b01;
        set_pos(1, 40); set_pos(0, 5);
        load(0, 64'h1234_5678_9ABC_DEF0, "R8");
        load(1, 64'h0F0F_F0F0_3C3C_C3C3, "R8");
        do_line("R8/R5", -1, 64'd0, 1'b0);

        // line E: active without line_start -> nothing (R10)
        load(0, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
        for (int x = 0; x < 40; x++) step(0, 1, x, "R10");
        step(0, 0, 0, "R10");
        step(0, 0, 0, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule